// File: doc/BRIEF.md
# Jump Address Fetch Sequencer

This block walks a 16-bit program counter through a byte-wide synchronous memory and understands only three opcodes: a one-byte filler that does nothing, a jump to an absolute address, and a jump through a pointer held in memory. It reads the operand bytes, resolves the pointer when needed and loads the program counter with the target. Each completed jump produces a one-cycle strobe while the program counter already shows the new value. A testbench or a larger core can therefore follow control flow without decoding anything.

A mode pin selects how the byte after the pointer is addressed. In legacy mode only the low byte of the pointer is incremented, so the high byte of a pointer that ends in 0xFF is read from offset 0x00 of the same 256-byte page. In corrected mode the increment carries into the next page. Any opcode outside the three is fatal. The sequencer stops fetching, raises `halted` and stays frozen until its reset input is asserted, which lets an external watchdog recover it.

The memory port is a request/grant stream. The block raises `mem_req` with an address. A request is taken on a rising edge where `mem_req` and `mem_gnt` are both high. While the grant is low, the request and its address stay unchanged. The byte for a taken request must be on `mem_rdata` during the cycle that follows, and no new request is raised in that cycle.

Top module: `jump_fetch_seq`

## Requirements
- R1: While reset is asserted and at release, `pc_o` equals START_ADDR (default 0x0010), `halted` is 0 and `jump_taken` is 0. The first opcode fetch is at START_ADDR.
- R2: A request that is not granted keeps `mem_req` high and `mem_addr` unchanged into the next cycle. A request granted at a rising edge is followed by one cycle with `mem_req` low, in which `mem_rdata` is taken.
- R3: Opcode 0xEA advances `pc_o` by one and raises no strobe.
- R4: Opcode 0x4C loads `pc_o` with the following two bytes, low byte first. This holds for every operand value, including operands whose bytes straddle a page boundary.
- R5: Opcode 0x6C forms a pointer from its two following bytes, low byte first. The target's low byte is read at the pointer and its high byte at the pointer's successor.
- R6: With `legacy_wrap` = 1 and a pointer low byte of 0xFF, the target's high byte is read from offset 0x00 of the pointer's own page.
- R7: With `legacy_wrap` = 0, the pointer's successor is the pointer plus one with full carry, so a pointer at 0xXXFF reads the high byte from the next page.
- R8: `jump_taken` is high for exactly one cycle per completed jump. In that cycle `pc_o` already holds the jump target.
- R9: Any opcode other than 0xEA, 0x4C or 0x6C sets `halted`. After that no request is issued and `pc_o` stays at the address of that opcode until reset.
- R10: Asserting reset while halted returns the block to the state of R1, and it then runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, also the recovery input |
| legacy_wrap | input | 1 | 1: pointer successor wraps in its page; 0: full carry. Hold it steady during an indirect jump |
| mem_req | output | 1 | Read request valid |
| mem_gnt | input | 1 | Read request accepted by memory (ready) |
| mem_addr | output | 16 | Read address, stable while `mem_req` is high and not yet granted |
| mem_rdata | input | 8 | Read byte, valid in the cycle after acceptance |
| pc_o | output | 16 | Current program counter |
| jump_taken | output | 1 | One-cycle pulse when a jump completes |
| halted | output | 1 | Sequencer frozen on an undefined opcode |

## Verification
The hardest case to reach from the ports is an indirect jump whose pointer ends in 0xFF. The two candidate high-byte locations must hold different values so that the two modes really diverge, and the pointer must be fetched while the grant is being withheld at random. The random programs chain a few dozen jumps through separate 1 KiB regions and force the 0xFF pointer case often. They write a distinct high byte at the location the other mode would read, so that taking the wrong path changes the very next target. Directed programs add opcodes and operands that straddle page boundaries, runs of filler bytes, and halt followed by recovery.

// File: rtl/jfs_pkg.sv
package jfs_pkg;
  localparam int BYTE_W = 8;
  localparam int PC_W   = 2 * BYTE_W;

  localparam logic [BYTE_W-1:0] OPC_NOP = 8'hEA;
  localparam logic [BYTE_W-1:0] OPC_ABS = 8'h4C;
  localparam logic [BYTE_W-1:0] OPC_IND = 8'h6C;

  typedef enum logic [1:0] {
    K_NOP, K_ABS, K_IND, K_BAD
  } op_kind_e;

  typedef enum logic [2:0] {
    ST_OPC,   // fetch opcode
    ST_ALO,   // fetch operand low byte
    ST_AHI,   // fetch operand high byte
    ST_PLO,   // fetch target low byte via pointer
    ST_PHI,   // fetch target high byte via pointer successor
    ST_HALT
  } seq_state_e;
endpackage

// File: rtl/jfs_decode.sv
module jfs_decode
  import jfs_pkg::*;
(
  input  logic [BYTE_W-1:0] opcode,
  output op_kind_e          kind
);
  always_comb begin
    unique case (opcode)
      OPC_NOP: kind = K_NOP;
      OPC_ABS: kind = K_ABS;
      OPC_IND: kind = K_IND;
      default: kind = K_BAD;
    endcase
  end
endmodule

// File: rtl/jfs_ptr_next.sv
module jfs_ptr_next #(
  parameter int ADDR_W    = 16,
  parameter int PAGE_BITS = 8
) (
  input  logic [ADDR_W-1:0] ptr,
  input  logic              legacy_wrap,
  output logic [ADDR_W-1:0] ptr_succ
);
  localparam int HI_W = ADDR_W - PAGE_BITS;

  logic [PAGE_BITS-1:0] off_inc;
  logic [ADDR_W-1:0]    full_inc;

  always_comb begin
    off_inc  = ptr[PAGE_BITS-1:0] + {{(PAGE_BITS-1){1'b0}}, 1'b1};
    full_inc = ptr + {{(ADDR_W-1){1'b0}}, 1'b1};
  end

  // legacy: page number untouched, only the in-page offset steps
  assign ptr_succ = legacy_wrap ? {ptr[ADDR_W-1 -: HI_W], off_inc} : full_inc;
endmodule

// File: rtl/jump_fetch_seq.sv
module jump_fetch_seq
  import jfs_pkg::*;
#(
  parameter logic [15:0] START_ADDR = 16'h0010,
  parameter int          PAGE_BITS  = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        legacy_wrap,
  output logic        mem_req,
  input  logic        mem_gnt,
  output logic [15:0] mem_addr,
  input  logic [7:0]  mem_rdata,
  output logic [15:0] pc_o,
  output logic        jump_taken,
  output logic        halted
);
  localparam logic [PC_W-1:0] PC_ONE = PC_W'(1);

  seq_state_e        state_q;
  logic              pend_q;     // one read in flight, data due this cycle
  logic              ind_q;      // current jump is indirect
  logic [PC_W-1:0]   pc_q;
  logic [PC_W-1:0]   ptr_q;
  logic [BYTE_W-1:0] lo_q;
  logic              jmp_q;

  op_kind_e          kind;
  logic [PC_W-1:0]   ptr_succ;

  jfs_decode u_dec (
    .opcode (mem_rdata),
    .kind   (kind)
  );

  jfs_ptr_next #(.ADDR_W(PC_W), .PAGE_BITS(PAGE_BITS)) u_pnx (
    .ptr         (ptr_q),
    .legacy_wrap (legacy_wrap),
    .ptr_succ    (ptr_succ)
  );

  always_comb begin
    mem_req = !pend_q && (state_q != ST_HALT);
    unique case (state_q)
      ST_PLO:  mem_addr = ptr_q;
      ST_PHI:  mem_addr = ptr_succ;
      default: mem_addr = pc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OPC;
      pend_q  <= 1'b0;
      ind_q   <= 1'b0;
      pc_q    <= START_ADDR;
      ptr_q   <= '0;
      lo_q    <= '0;
      jmp_q   <= 1'b0;
    end else begin
      jmp_q <= 1'b0;
      if (mem_req && mem_gnt) pend_q <= 1'b1;
      if (pend_q) begin
        pend_q <= 1'b0;
        unique case (state_q)
          ST_OPC: begin
            unique case (kind)
              K_NOP: pc_q <= pc_q + PC_ONE;
              K_ABS: begin
                pc_q <= pc_q + PC_ONE; ind_q <= 1'b0; state_q <= ST_ALO;
              end
              K_IND: begin
                pc_q <= pc_q + PC_ONE; ind_q <= 1'b1; state_q <= ST_ALO;
              end
              default: state_q <= ST_HALT;  // pc stays on the bad opcode
            endcase
          end
          ST_ALO: begin
            lo_q    <= mem_rdata;
            pc_q    <= pc_q + PC_ONE;
            state_q <= ST_AHI;
          end
          ST_AHI: begin
            if (ind_q) begin
              ptr_q   <= {mem_rdata, lo_q};
              state_q <= ST_PLO;
            end else begin
              pc_q    <= {mem_rdata, lo_q};
              jmp_q   <= 1'b1;
              state_q <= ST_OPC;
            end
          end
          ST_PLO: begin
            lo_q    <= mem_rdata;
            state_q <= ST_PHI;
          end
          ST_PHI: begin
            pc_q    <= {mem_rdata, lo_q};
            jmp_q   <= 1'b1;
            state_q <= ST_OPC;
          end
          default: state_q <= ST_HALT;
        endcase
      end
    end
  end

  assign pc_o       = pc_q;
  assign jump_taken = jmp_q;
  assign halted     = (state_q == ST_HALT);
endmodule

// File: rtl/jfs_checker.sv
module jfs_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_gnt,
  input logic [15:0] mem_addr,
  input logic [15:0] pc_o,
  input logic        jump_taken,
  input logic        halted
);
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

  assert_one_outstanding_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_gnt) |=> !mem_req);

  assert_strobe_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    jump_taken |=> !jump_taken);

  assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(pc_o)));

  assert_no_strobe_halted_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !jump_taken);
endmodule

bind jump_fetch_seq jfs_checker u_jfs_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_req    (mem_req),
  .mem_gnt    (mem_gnt),
  .mem_addr   (mem_addr),
  .pc_o       (pc_o),
  .jump_taken (jump_taken),
  .halted     (halted)
);

// File: tb/jump_fetch_seq_tb.sv
module jump_fetch_seq_tb_top;
  localparam int          CLK_PERIOD = 10;
  localparam logic [15:0] START      = 16'h0010;
  localparam int          WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        legacy_wrap = 1'b1;
  logic        mem_req, mem_gnt;
  logic [15:0] mem_addr, pc_o;
  logic [7:0]  mem_rdata;
  logic        jump_taken, halted;

  int n_cmp = 0;
  int n_bad = 0;

  logic [7:0]  mem [int];
  logic [15:0] exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  jump_fetch_seq #(.START_ADDR(START)) dut_i (
    .clk(clk), .rst_n(rst_n), .legacy_wrap(legacy_wrap),
    .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .pc_o(pc_o), .jump_taken(jump_taken),
    .halted(halted)
  );

  function automatic logic [7:0] rd(int a);
    return mem.exists(a) ? mem[a] : 8'h02;
  endfunction

  // successor of a pointer according to R6 / R7
  function automatic logic [15:0] succ(logic [15:0] p, logic legacy);
    return legacy ? {p[15:8], p[7:0] + 8'd1} : p + 16'd1;
  endfunction

  function automatic logic [15:0] exp_ind(logic [15:0] p, logic legacy);
    return {rd(int'(succ(p, legacy))), rd(int'(p))};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // memory model: random grant, byte returned the cycle after acceptance
  initial begin
    bit acc = 0;
    bit hold_chk = 0;
    logic [15:0] a = '0;
    logic [15:0] hold_a = '0;
    mem_gnt = 1'b0;
    mem_rdata = 8'h00;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        acc = 0; hold_chk = 0; mem_gnt = 1'b0;
      end else begin
        if (acc) mem_rdata = rd(int'(a));
        if (hold_chk) chk("R2 held request", {15'd0, mem_req, mem_addr}, {16'd1, hold_a});
        mem_gnt  = ($urandom % 4) != 0;
        acc      = mem_req && mem_gnt;
        hold_chk = mem_req && !mem_gnt;
        a        = mem_addr;
        hold_a   = mem_addr;
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  task automatic do_reset(string tag);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk({tag, " pc in reset"}, pc_o, START);
    chk({tag, " flags in reset"}, {halted, jump_taken}, 0);
    chk({tag, " first fetch address"}, mem_addr, START);
    #1 rst_n = 1'b1;
  endtask

  task automatic run_prog(string tag, int lim);
    bit prev_j = 0;
    for (int c = 0; c < lim && !halted; c++) begin
      @(negedge clk);
      if (jump_taken) begin
        if (exp_q.size() == 0) chk("R8 unexpected strobe", 1, 0);
        else chk(tag, pc_o, exp_q.pop_front());
        if (prev_j) chk("R8 strobe longer than one cycle", 1, 0);
      end
      prev_j = jump_taken;
    end
    chk({tag, " all jumps done"}, exp_q.size(), 0);
  endtask

  task automatic check_frozen(logic [15:0] exp_pc);
    int reqs = 0;
    chk("R9 halted set", halted, 1);
    chk("R9 pc on bad opcode", pc_o, exp_pc);
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (mem_req || jump_taken) reqs++;
      if (pc_o !== exp_pc) reqs++;
    end
    chk("R9 no activity while halted", reqs, 0);
  endtask

  function automatic logic [7:0] bad_opcode();
    logic [7:0] v;
    do v = 8'($urandom); while (v == 8'hEA || v == 8'h4C || v == 8'h6C);
    return v;
  endfunction

  // directed: page-straddling operands, then an indirect through xxFF
  task automatic directed_pages(logic legacy);
    logic [15:0] t;
    mem.delete(); exp_q.delete();
    legacy_wrap = legacy;
    mem[16'h0010] = 8'hEA;                         // R3
    mem[16'h0011] = 8'h4C; mem[16'h0012] = 8'hFE; mem[16'h0013] = 8'h01;
    mem[16'h01FE] = 8'h4C; mem[16'h01FF] = 8'hFF; mem[16'h0200] = 8'h34;
    mem[16'h34FF] = 8'h6C; mem[16'h3500] = 8'hFF; mem[16'h3501] = 8'h12;
    mem[16'h12FF] = 8'h78; mem[16'h1200] = 8'h56; mem[16'h1300] = 8'h9A;
    mem[16'h5678] = 8'hFF; mem[16'h9A78] = 8'hFF;
    t = exp_ind(16'h12FF, legacy);
    exp_q.push_back(16'h01FE);
    exp_q.push_back(16'h34FF);
    exp_q.push_back(t);
    do_reset("R1");
    run_prog(legacy ? "R4_R6 page straddle" : "R4_R7 page straddle", 400);
    chk(legacy ? "R6 wrapped target" : "R7 carried target", t,
        legacy ? 16'h5678 : 16'h9A78);
    check_frozen(t);
  endtask

  // random chain of jumps, one 1 KiB region per instruction
  task automatic random_chain(int n, logic legacy);
    logic [15:0] cur, tgt, p, alt;
    mem.delete(); exp_q.delete();
    legacy_wrap = legacy;
    cur = START;
    for (int i = 0; i < n; i++) begin
      int nops = $urandom % 3;
      for (int k = 0; k < nops; k++) begin mem[int'(cur)] = 8'hEA; cur++; end
      tgt = 16'((i + 1) * 16'h0400 + 16'h0010 + ($urandom % 16'h00E0));
      if ($urandom % 2) begin
        mem[int'(cur)] = 8'h4C; mem[int'(cur + 1)] = tgt[7:0]; mem[int'(cur + 2)] = tgt[15:8];
      end else begin
        p = 16'(i * 16'h0400 + 16'h0200);
        p[7:0] = ($urandom % 3 == 0) ? 8'hFF : 8'($urandom % 255);
        mem[int'(cur)] = 8'h6C; mem[int'(cur + 1)] = p[7:0]; mem[int'(cur + 2)] = p[15:8];
        mem[int'(p)] = tgt[7:0];
        mem[int'(succ(p, legacy))] = tgt[15:8];
        alt = succ(p, !legacy);
        if (alt != succ(p, legacy)) mem[int'(alt)] = tgt[15:8] ^ 8'h20;
      end
      exp_q.push_back(tgt);
      cur = tgt;
    end
    mem[int'(cur)] = bad_opcode();
    do_reset("R10 recovery");
    run_prog(legacy ? "R4_R5_R6 random chain" : "R4_R5_R7 random chain", 20000);
    check_frozen(cur);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    // R3: a run of fillers then an undefined opcode
    mem.delete(); exp_q.delete();
    for (int k = 0; k < 5; k++) mem[int'(START) + k] = 8'hEA;
    mem[int'(START) + 5] = 8'h00;
    do_reset("R1");
    run_prog("R3 fillers only", 200);
    check_frozen(START + 16'd5);

    directed_pages(1'b1);
    directed_pages(1'b0);
    for (int r = 0; r < 4; r++) random_chain(30, r[0]);
    finish_run();
  end
endmodule